// File: doc/BRIEF.md
# Horizontal Line Timing Generator

This block produces the horizontal timing for each scan line of a small video chip. It does not use a binary line counter. A six-bit linear-feedback shift counter advances once every four color clocks. The block decodes a few states of this counter, and those decodes set and clear flip-flops that drive horizontal blank, horizontal sync (active low) and colour burst. When the counter reaches its end state it goes back to all zeros, so one line lasts 57 counts, or 228 color clocks.

The blank output changes half a color clock after the count edge. This places its transitions on the rising edge of the inverted pixel clock. Software can end a line early with a one-clock line-reset strobe. The strobe sends the counter back to its start and restarts the clock divider, so a full new line begins at once. The block also outputs the current counter state and a one-clock count-enable pulse, which neighbouring logic can decode for its own timing.

Top module: `hline_timing_gen`

## Requirements
- R1: `lineState` changes only at a clock edge where `countTick` is high. In each line it visits these states, with bit 0 written first, for counts 0 to 17: 000000, 100000, 110000, 111000, 111100, 111110, 011111, 101111, 110111, 111011, 111101, 011110, 001111, 100111, 110011, 111001, 011100, 101110. For counts 55 and 56 it visits 101001 and 010100.
- R2: `countTick` is high for exactly one clock in every four. That clock is the last one of a count.
- R3: A line holds 57 distinct counter states and lasts 228 clocks. The all-ones state never appears. The state after 010100 (bit 0 first) is all zeros.
- R4: Count 0 is the all-zeros state. `hBlank` is high for counts 0 to 16, which is 68 clocks, and low for the rest of the line.
- R5: `hSyncN` is low for counts 5 to 8, which is 16 clocks, and high otherwise.
- R6: `colorBurst` is high for counts 9 to 12, which is 16 clocks. It is never high while sync is active.
- R7: `hBlank` changes on the falling clock edge that follows the rising edge that starts count 0 or count 17.
- R8: A `lineReset` pulse sampled at a rising edge does the following at that edge: the state goes to all zeros, `hBlank` goes high, `hSyncN` goes high and `colorBurst` goes low. The next tick comes three clocks later, and a full 228-clock line follows. The strobe takes priority over a count step in the same clock, including one that would have started sync.
- R9: While `rst` is sampled high, the block drives state all zeros, `hBlank` high, `hSyncN` high, `colorBurst` low and `countTick` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Color clock |
| rst | input | 1 | Synchronous reset, active high |
| lineReset | input | 1 | One-clock strobe that restarts the line |
| hBlank | output | 1 | Horizontal blank, changed on the falling edge |
| hSyncN | output | 1 | Horizontal sync, active low |
| colorBurst | output | 1 | Colour burst window |
| countTick | output | 1 | Count-enable pulse, once per four clocks |
| lineState | output | 6 | Current counter state, bit 0 is the first bit of the sequence |

## Verification
A line-reset strobe and a count step can land in the same clock. The critical case is a strobe on the tick where the counter sits in the set-sync state. In that case the sync decode and the restart both try to act on the same edge. The bench waits for that exact sample and raises the strobe. It then expects sync to stay inactive, the state to be all zeros and blank to be high. It also expects the line that follows to match the normal blank, sync and burst pattern over its full 228 clocks.

// File: rtl/htg_pkg.sv
package htg_pkg;
  localparam int unsigned STATE_W = 6;
  typedef logic [STATE_W-1:0] lineState_t;

  // Decoded states, stored as values (bit 0 is the first bit of the sequence)
  localparam lineState_t ST_END       = 6'b001010;
  localparam lineState_t ST_SET_SYNC  = 6'b001111;
  localparam lineState_t ST_RST_SYNC  = 6'b111011;
  localparam lineState_t ST_RST_BURST = 6'b111100;
  localparam lineState_t ST_RST_BLANK = 6'b001110;

  typedef struct packed {
    logic step;
    logic restart;
  } htgStrobes_t;
endpackage

// File: rtl/htg_ctrl.sv
module htg_ctrl
  import htg_pkg::*;
#(
  parameter int unsigned CLOCKS_PER_COUNT = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        lineReset,
  output htgStrobes_t strobes,
  output logic        countTick
);
  localparam int unsigned DIV_W = (CLOCKS_PER_COUNT > 2) ? $clog2(CLOCKS_PER_COUNT) : 1;
  localparam logic [DIV_W-1:0] PRE_LAST = DIV_W'(CLOCKS_PER_COUNT - 2);

  logic [DIV_W-1:0] divQ;
  logic             tickQ;

  always_ff @(posedge clk) begin
    if (rst || lineReset) begin
      divQ  <= '0;
      tickQ <= 1'b0;
    end else begin
      tickQ <= (divQ == PRE_LAST);
      divQ  <= tickQ ? '0 : divQ + 1'b1;
    end
  end

  always_comb begin
    strobes.step    = tickQ && !lineReset;
    strobes.restart = lineReset;
  end

  assign countTick = tickQ;
endmodule

// File: rtl/htg_datapath.sv
module htg_datapath
  import htg_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  htgStrobes_t strobes,
  output lineState_t  lineState,
  output logic        hBlank,
  output logic        hSyncN,
  output logic        colorBurst
);
  lineState_t stateQ;
  lineState_t shifted;
  logic blankQ, syncNQ, burstQ, blankOutQ;
  logic atEnd, atSetSync, atRstSync, atRstBurst, atRstBlank;

  always_comb begin
    shifted    = {stateQ[STATE_W-2:0], ~(stateQ[STATE_W-1] ^ stateQ[STATE_W-2])};
    atEnd      = (stateQ == ST_END);
    atSetSync  = (stateQ == ST_SET_SYNC);
    atRstSync  = (stateQ == ST_RST_SYNC);
    atRstBurst = (stateQ == ST_RST_BURST);
    atRstBlank = (stateQ == ST_RST_BLANK);
  end

  always_ff @(posedge clk) begin
    if (rst || strobes.restart) begin
      stateQ <= '0;
      blankQ <= 1'b1;
      syncNQ <= 1'b1;
      burstQ <= 1'b0;
    end else if (strobes.step) begin
      stateQ <= atEnd ? '0 : shifted;
      if (atEnd)           blankQ <= 1'b1;
      else if (atRstBlank) blankQ <= 1'b0;
      if (atSetSync)       syncNQ <= 1'b0;
      else if (atRstSync)  syncNQ <= 1'b1;
      if (atRstSync)       burstQ <= 1'b1;
      else if (atRstBurst) burstQ <= 1'b0;
    end
  end

  // Half-clock retime of blank onto the inverted pixel clock
  always_ff @(negedge clk) begin
    blankOutQ <= rst ? 1'b1 : blankQ;
  end

  assign lineState  = stateQ;
  assign hBlank     = blankOutQ;
  assign hSyncN     = syncNQ;
  assign colorBurst = burstQ;
endmodule

// File: rtl/hline_timing_gen.sv
module hline_timing_gen
  import htg_pkg::*;
#(
  parameter int unsigned CLOCKS_PER_COUNT = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       lineReset,
  output logic       hBlank,
  output logic       hSyncN,
  output logic       colorBurst,
  output logic       countTick,
  output logic [5:0] lineState
);
  htgStrobes_t strobes;

  htg_ctrl #(.CLOCKS_PER_COUNT(CLOCKS_PER_COUNT)) ctrl_i (
    .clk(clk), .rst(rst), .lineReset(lineReset),
    .strobes(strobes), .countTick(countTick)
  );

  htg_datapath dp_i (
    .clk(clk), .rst(rst), .strobes(strobes),
    .lineState(lineState), .hBlank(hBlank),
    .hSyncN(hSyncN), .colorBurst(colorBurst)
  );
endmodule

// File: rtl/htg_checker.sv
module htg_checker
  import htg_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       lineReset,
  input logic       hBlank,
  input logic       hSyncN,
  input logic       colorBurst,
  input logic       countTick,
  input logic [5:0] lineState
);
  a_r1_hold_between_ticks: assert property (@(posedge clk) disable iff (rst)
    (!countTick && !lineReset) |=> $stable(lineState));

  a_r2_tick_single: assert property (@(posedge clk) disable iff (rst)
    countTick |=> !countTick);

  a_r3_end_wraps: assert property (@(posedge clk) disable iff (rst)
    (countTick && lineState == ST_END) |=> (lineState == '0));

  a_r4_blank_covers_sync_burst: assert property (@(posedge clk) disable iff (rst)
    (!hSyncN || colorBurst) |-> hBlank);

  a_r6_burst_outside_sync: assert property (@(posedge clk) disable iff (rst)
    !(colorBurst && !hSyncN));

  a_r8_restart: assert property (@(posedge clk) disable iff (rst)
    lineReset |=> (lineState == '0 && hSyncN && !colorBurst && !countTick));
endmodule

bind hline_timing_gen htg_checker chk_i (
  .clk(clk), .rst(rst), .lineReset(lineReset), .hBlank(hBlank),
  .hSyncN(hSyncN), .colorBurst(colorBurst), .countTick(countTick),
  .lineState(lineState)
);

// File: tb/hline_timing_gen_test.sv
module hline_timing_gen_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic lineReset = 1'b0;
  logic hBlank, hSyncN, colorBurst, countTick;
  logic [5:0] lineState;

  int nRun = 0;
  int nFail = 0;
  logic [5:0] lineStates [57];

  localparam int TBL_N = 20;
  localparam int TBL_K [TBL_N] = '{55, 56, 0, 1, 2, 3, 4, 5, 6, 7, 8, 9, 10, 11, 12, 13, 14, 15, 16, 17};
  // written bit 0 first
  localparam logic [5:0] TBL_LF [TBL_N] = '{
    6'b101001, 6'b010100, 6'b000000, 6'b100000, 6'b110000, 6'b111000, 6'b111100,
    6'b111110, 6'b011111, 6'b101111, 6'b110111, 6'b111011, 6'b111101, 6'b011110,
    6'b001111, 6'b100111, 6'b110011, 6'b111001, 6'b011100, 6'b101110};

  always #10 clk = ~clk;

  hline_timing_gen uut (
    .clk(clk), .rst(rst), .lineReset(lineReset), .hBlank(hBlank),
    .hSyncN(hSyncN), .colorBurst(colorBurst), .countTick(countTick),
    .lineState(lineState)
  );

  function automatic logic [5:0] fromLowFirst(input logic [5:0] v);
    logic [5:0] r;
    for (int i = 0; i < 6; i++) r[i] = v[5-i];
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic nextSample();
    @(negedge clk);
    #2;
  endtask

  task automatic waitWrap();
    logic [5:0] prev;
    prev = lineState;
    nextSample();
    while (!(prev != 6'd0 && lineState == 6'd0)) begin
      prev = lineState;
      nextSample();
    end
  endtask

  // Starts at sample c=0 of a line; ends at c=0 of the next line
  task automatic checkLines(input int n, input bit record);
    logic [5:0] prev;
    bit seen [64];
    int uniq;
    for (int ln = 0; ln < n; ln++) begin
      for (int i = 0; i < 64; i++) seen[i] = 1'b0;
      uniq = 0;
      prev = lineState;
      for (int c = 0; c < 228; c++) begin
        int k;
        k = c / 4;
        if (c == 0) chk(lineState == 6'd0, "R4", "state at count 0", lineState, 0);
        else if (c % 4 == 0) chk(lineState != prev, "R1", "state step", lineState, prev);
        else chk(lineState == prev, "R1", "state hold", lineState, prev);
        if (c % 4 == 0) begin
          if (!seen[lineState]) uniq++;
          seen[lineState] = 1'b1;
          if (record && ln == 0) lineStates[k] = lineState;
        end
        chk(countTick == (c % 4 == 3), "R2", "countTick", countTick, (c % 4 == 3));
        chk(hBlank == (k <= 16), "R4", "hBlank", hBlank, (k <= 16));
        chk(hSyncN == !(k >= 5 && k <= 8), "R5", "hSyncN", hSyncN, !(k >= 5 && k <= 8));
        chk(colorBurst == (k >= 9 && k <= 12), "R6", "colorBurst", colorBurst, (k >= 9 && k <= 12));
        prev = lineState;
        nextSample();
      end
      chk(uniq == 57, "R3", "distinct states", uniq, 57);
      chk(!seen[63], "R3", "all-ones seen", seen[63], 0);
      chk(lineState == 6'd0, "R3", "wrap after 228 clocks", lineState, 0);
    end
  endtask

  initial begin
    #(200000 * 20);
    nFail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    // R9: reset state
    nextSample();
    nextSample();
    chk(lineState == 6'd0, "R9", "state in reset", lineState, 0);
    chk(hBlank == 1'b1, "R9", "hBlank in reset", hBlank, 1);
    chk(hSyncN == 1'b1, "R9", "hSyncN in reset", hSyncN, 1);
    chk(colorBurst == 1'b0, "R9", "colorBurst in reset", colorBurst, 0);
    chk(countTick == 1'b0, "R9", "countTick in reset", countTick, 0);
    rst = 1'b0;

    // Main pattern over three lines, recording the first
    waitWrap();
    checkLines(3, 1'b1);

    // R1: walk the state table
    for (int t = 0; t < TBL_N; t++)
      chk(lineStates[TBL_K[t]] == fromLowFirst(TBL_LF[t]), "R1", "table state",
          lineStates[TBL_K[t]], fromLowFirst(TBL_LF[t]));

    // R7: half-clock retime of blank at both edges
    while (!(countTick && lineState == fromLowFirst(6'b010100))) nextSample();
    @(posedge clk); #2;
    chk(lineState == 6'd0, "R3", "zeros after end state", lineState, 0);
    chk(hBlank == 1'b0, "R7", "blank before falling edge (rise)", hBlank, 0);
    @(negedge clk); #2;
    chk(hBlank == 1'b1, "R7", "blank after falling edge (rise)", hBlank, 1);
    for (int c = 0; c < 67; c++) nextSample();
    chk(countTick == 1'b1, "R7", "at last clock of count 16", countTick, 1);
    @(posedge clk); #2;
    chk(hBlank == 1'b1, "R7", "blank before falling edge (fall)", hBlank, 1);
    @(negedge clk); #2;
    chk(hBlank == 1'b0, "R7", "blank after falling edge (fall)", hBlank, 0);

    // R8: mid-count strobe in the visible part of the line
    for (int c = 0; c < 33; c++) nextSample();
    chk(countTick == 1'b0, "R8", "strobe lands mid-count", countTick, 0);
    lineReset = 1'b1;
    nextSample();
    lineReset = 1'b0;
    chk(hBlank == 1'b1, "R8", "blank after strobe", hBlank, 1);
    checkLines(1, 1'b0);

    // R8: strobe on the tick at the set-sync state (restart wins)
    while (!(countTick && lineState == fromLowFirst(6'b111100))) nextSample();
    lineReset = 1'b1;
    nextSample();
    lineReset = 1'b0;
    chk(lineState == 6'd0, "R8", "state after coincident strobe", lineState, 0);
    chk(hSyncN == 1'b1, "R8", "sync suppressed", hSyncN, 1);
    chk(colorBurst == 1'b0, "R8", "burst after strobe", colorBurst, 0);
    chk(hBlank == 1'b1, "R8", "blank after coincident strobe", hBlank, 1);
    checkLines(2, 1'b0);

    // R9: reset in the middle of burst
    while (!colorBurst) nextSample();
    rst = 1'b1;
    nextSample();
    chk(lineState == 6'd0, "R9", "state mid-line reset", lineState, 0);
    chk(colorBurst == 1'b0, "R9", "burst mid-line reset", colorBurst, 0);
    chk(hSyncN == 1'b1, "R9", "sync mid-line reset", hSyncN, 1);
    chk(hBlank == 1'b1, "R9", "blank mid-line reset", hBlank, 1);
    chk(countTick == 1'b0, "R9", "tick mid-line reset", countTick, 0);
    nextSample();
    rst = 1'b0;
    waitWrap();
    checkLines(1, 1'b0);

    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule